// File: doc/BRIEF.md
# Sticky Right Shifter, 128-bit

This block is a purely combinational logical right shifter for a 128-bit significand carried as two 64-bit halves. Every bit pushed out past bit 0 is not simply lost: all such bits are OR-reduced into one sticky flag, and that flag is ORed into bit 0 of the shifted result. A later rounding stage can then still tell an exact result from an inexact one.

The block sits in floating-point operand alignment and in the final placement of a wide significand before rounding. The shift count is an unsigned 8-bit value and every value is legal. Counts at or beyond the word width collapse the result to a single sticky bit. Rounding, left shifts and sign-filling shifts belong to other blocks.

Top module: `srs_sticky_rshift`

## Requirements
- R1: A shift count of 0 returns both halves unchanged, and the sticky bit has no effect.
- R2: For counts 1 to 63, the high half shifts right by the count, and its low bits cross into the top of the low half. Bit 0 of the result is ORed with the OR of the bits dropped from the old low half.
- R3: For a count of exactly 64, the low output half is the old high half with its bit 0 ORed with a flag that is set when the old low half was nonzero. The high output half is zero.
- R4: For counts 65 to 127, the high output half is zero. The low output half is the old high half shifted right by (count − 64), with bit 0 ORed with the OR of every discarded high-half bit and every old low-half bit.
- R5: For counts 128 to 255, the high output half and bits 63..1 of the low output half are zero. Bit 0 is 1 exactly when any input bit was set.
- R6: The sticky bit is ORed into bit 0 of the shifted value and never replaces it. A shifted-in 1 at bit 0 stays 1 whether or not the dropped bits are zero.
- R7: An all-zero input gives an all-zero output for every count. A nonzero input never gives an all-zero output.
- R8: The output is a combinational function of the present inputs with no clock and no stored state. It equals (input >> count) with bit 0 ORed by the OR of all bits shifted out.
- R9: The count port is 8 bits wide, so all 256 count values, including 255, are accepted and handled by the rules above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_hi | input | 64 | Upper half (bits 127..64) of the value to shift |
| in_lo | input | 64 | Lower half (bits 63..0) of the value to shift |
| shamt | input | 8 | Unsigned right-shift count, 0 to 255 |
| out_hi | output | 64 | Upper half of the shifted result |
| out_lo | output | 64 | Lower half of the shifted result, sticky bit folded into bit 0 |

## Verification
The hardest case to reach from the ports is one where bit 0 of the plain shifted value and the sticky flag are both set, or where only one of them is set. Random operands almost never place a lone set bit exactly where the shift moves it to position 0, and they almost never leave every dropped bit clear. The vector table therefore uses sparse operands with single bits placed just above and below each shift boundary (counts 1, 63, 64, 65, 127, 128 and 255), so both sources of bit 0 can be told apart. Random sweeps against a 384-bit reference shift then cover the dense cases.

// File: rtl/srs_pkg.sv
// Package: shared widths for the sticky right shifter.
// Assumes the data width is a power of two and split into two equal halves.
package srs_pkg;
    localparam int unsigned SRS_DATA_W = 128;
    localparam int unsigned SRS_HALF_W = SRS_DATA_W / 2;
    localparam int unsigned SRS_CNT_W  = 8;
endpackage

// File: rtl/srs_stage.sv
// Module: srs_stage
// One fixed-distance stage of the log shifter. When enabled it shifts the
// value right by AMT and reports whether any bit fell off the low end.
// Assumes 1 <= AMT < W.
module srs_stage #(
    parameter int unsigned W   = 128,
    parameter int unsigned AMT = 1
) (
    input  logic [W-1:0] d,
    input  logic         en,
    output logic [W-1:0] q,
    output logic         drop
);
    // Select shifted or passed-through value and flag any lost ones.
    always_comb begin
        q    = en ? (d >> AMT) : d;
        drop = en & (|d[AMT-1:0]);
    end
endmodule

// File: rtl/srs_saturate.sv
// Module: srs_saturate
// Detects counts at or beyond the word width and builds the collapsed
// result: a single sticky bit telling whether any input bit was set.
// Assumes CNT_W may be larger than, equal to, or smaller than IDX_W.
module srs_saturate #(
    parameter int unsigned W     = 128,
    parameter int unsigned CNT_W = 8
) (
    input  logic [W-1:0]     d,
    input  logic [CNT_W-1:0] cnt,
    output logic             sat,
    output logic [W-1:0]     q
);
    localparam int unsigned IDX_W = $clog2(W);

    generate
        if (CNT_W > IDX_W) begin : g_wide_cnt
            // Any count bit at or above log2(W) means count >= W.
            always_comb sat = |cnt[CNT_W-1:IDX_W];
        end else begin : g_narrow_cnt
            // A count this narrow can never reach the word width.
            always_comb sat = 1'b0;
        end
    endgenerate

    // Collapse the whole word into bit 0.
    always_comb q = {{(W-1){1'b0}}, |d};
endmodule

// File: rtl/srs_sticky_rshift.sv
// Module: srs_sticky_rshift (top)
// Combinational logical right shift of a two-half significand. Bits shifted
// out past bit 0 are ORed into bit 0 of the result (sticky). A log shifter
// covers counts below the width; counts at or above it are saturated.
// Assumes no clock; the output settles from the present inputs.
module srs_sticky_rshift
    import srs_pkg::*;
(
    input  logic [SRS_HALF_W-1:0] in_hi,
    input  logic [SRS_HALF_W-1:0] in_lo,
    input  logic [SRS_CNT_W-1:0]  shamt,
    output logic [SRS_HALF_W-1:0] out_hi,
    output logic [SRS_HALF_W-1:0] out_lo
);
    localparam int unsigned W      = SRS_DATA_W;
    localparam int unsigned STAGES = $clog2(W);
    localparam int unsigned LOW_CNT_W = (SRS_CNT_W < STAGES) ? SRS_CNT_W : STAGES;

    logic [W-1:0]      word_in;
    logic [W-1:0]      chain [STAGES+1];
    logic [STAGES-1:0] drops;
    logic [STAGES-1:0] stage_en;
    logic [W-1:0]      sat_word;
    logic              sat;
    logic [W-1:0]      result;

    // Join the two halves into one working word.
    always_comb word_in = {in_hi, in_lo};

    // Stage enables come from the low count bits; missing bits stay off.
    always_comb begin
        stage_en = '0;
        stage_en[LOW_CNT_W-1:0] = shamt[LOW_CNT_W-1:0];
    end

    // Head of the shift chain.
    always_comb chain[0] = word_in;

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            srs_stage #(
                .W   (W),
                .AMT (1 << k)
            ) u_stage (
                .d    (chain[k]),
                .en   (stage_en[k]),
                .q    (chain[k+1]),
                .drop (drops[k])
            );
        end
    endgenerate

    srs_saturate #(
        .W     (W),
        .CNT_W (SRS_CNT_W)
    ) u_sat (
        .d   (word_in),
        .cnt (shamt),
        .sat (sat),
        .q   (sat_word)
    );

    // Pick saturated word or shifted word with sticky folded into bit 0.
    always_comb begin
        if (sat) result = sat_word;
        else     result = chain[STAGES] | {{(W-1){1'b0}}, |drops};
    end

    // Split the result back into halves.
    always_comb begin
        out_hi = result[W-1:SRS_HALF_W];
        out_lo = result[SRS_HALF_W-1:0];
    end

    // Port-level checks on the settled result.
    always_comb begin
        if (shamt == '0)
            p_pass_r1: assert ({out_hi, out_lo} == word_in)
                else $error("count 0 altered value");
        if (shamt >= SRS_CNT_W'(SRS_HALF_W))
            p_hi_clear_r3: assert (out_hi == '0)
                else $error("high half not cleared");
        if (shamt >= SRS_CNT_W'(W - 1) && shamt != SRS_CNT_W'(W - 1))
            p_sat_single_r5: assert (out_hi == '0 && out_lo[SRS_HALF_W-1:1] == '0
                                     && out_lo[0] == (|word_in))
                else $error("saturated result malformed");
        if (word_in == '0)
            p_zero_in_r7: assert ({out_hi, out_lo} == '0)
                else $error("zero input gave nonzero output");
        if (word_in != '0)
            p_nonzero_r7: assert ({out_hi, out_lo} != '0)
                else $error("nonzero input lost entirely");
        if (shamt < SRS_CNT_W'(W) && word_in[shamt[STAGES-1:0]])
            p_or_keep_r6: assert (out_lo[0])
                else $error("shifted bit 0 replaced");
    end
endmodule

// File: tb/tb_srs_sticky_rshift.sv
// Bench for srs_sticky_rshift: a vector table walk, directed corners and
// random sweeps against a wide reference shift.
module tb_srs_sticky_rshift;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 18;
    localparam int  WATCHDOG_CYC = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [63:0]  in_hi, in_lo, out_hi, out_lo;
    logic [7:0]   shamt;
    int           n_checks = 0;
    int           n_fails = 0;
    bit           finished = 0;

    localparam logic [127:0] V_IN [NVEC] = '{
        128'h1, 128'h1, 128'h3, 128'h4,
        128'h8000_0000_0000_0000_0000_0000_0000_0000,
        128'h8000_0000_0000_0000_0000_0000_0000_0000,
        128'h0000_0000_0000_0001_0000_0000_0000_0000,
        128'h0000_0000_0000_0002_0000_0000_0000_0001,
        128'h0000_0000_0000_0003_0000_0000_0000_0001,
        128'hF000_0000_0000_0000_0000_0000_0000_0000,
        128'h0000_0000_0000_0010_0000_0000_0000_0000,
        128'h0000_0000_0000_0010_0000_0000_0000_0000,
        128'h100, 128'h100, 128'h100, 128'h0,
        128'h0000_0000_0000_0001_0000_0000_0000_0000,
        128'h0000_0000_0000_0001_0000_0000_0000_0001
    };
    localparam logic [7:0] V_CNT [NVEC] = '{
        8'd0, 8'd1, 8'd1, 8'd1, 8'd127, 8'd128, 8'd64, 8'd64, 8'd64,
        8'd65, 8'd68, 8'd69, 8'd8, 8'd9, 8'd255, 8'd255, 8'd1, 8'd63
    };
    localparam logic [127:0] V_EXP [NVEC] = '{
        128'h1, 128'h1, 128'h1, 128'h2, 128'h1, 128'h1, 128'h1, 128'h3, 128'h3,
        128'h0000_0000_0000_0000_7800_0000_0000_0000,
        128'h1, 128'h1, 128'h1, 128'h1, 128'h1, 128'h0,
        128'h0000_0000_0000_0000_8000_0000_0000_0000,
        128'h3
    };
    localparam string V_REQ [NVEC] = '{
        "R1", "R2", "R6", "R2", "R4", "R5", "R3", "R3", "R6",
        "R4", "R4", "R4", "R2", "R2", "R9", "R7", "R2", "R2"
    };

    srs_sticky_rshift dut (
        .in_hi  (in_hi),
        .in_lo  (in_lo),
        .shamt  (shamt),
        .out_hi (out_hi),
        .out_lo (out_lo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [127:0] ref_shift(input logic [127:0] v, input logic [7:0] c);
        logic [383:0] wide;
        wide = {v, 256'b0} >> c;
        return wide[383:256] | {127'b0, |wide[255:0]};
    endfunction

    task automatic check(input string req, input logic [127:0] exp);
        n_checks++;
        if ({out_hi, out_lo} !== exp) begin
            n_fails++;
            $display("FAIL %s: in=%h cnt=%0d got %h expected %h",
                     req, {in_hi, in_lo}, shamt, {out_hi, out_lo}, exp);
        end
    endtask

    task automatic apply(input logic [127:0] v, input logic [7:0] c);
        @(negedge clk);
        {in_hi, in_lo} = v;
        shamt = c;
        #1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG_CYC; i++) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [127:0] v;
        in_hi = '0; in_lo = '0; shamt = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // Initial state: zero inputs give zero output (R7).
        apply(128'h0, 8'd0);
        check("R7", 128'h0);

        for (int i = 0; i < NVEC; i++) begin
            apply(V_IN[i], V_CNT[i]);
            check(V_REQ[i], V_EXP[i]);
        end

        // R8: output follows a new input with no clock edge.
        {in_hi, in_lo} = 128'h0000_0000_0000_0004_0000_0000_0000_0000;
        shamt = 8'd66;
        #1;
        check("R8", 128'h1);

        // Boundary counts on random data (R2, R3, R4, R5, R9).
        for (int b = 0; b < 8; b++) begin
            logic [7:0] c;
            case (b)
                0: c = 8'd0;   1: c = 8'd1;   2: c = 8'd63;  3: c = 8'd64;
                4: c = 8'd65;  5: c = 8'd127; 6: c = 8'd128; default: c = 8'd255;
            endcase
            for (int r = 0; r < 40; r++) begin
                v = {$urandom, $urandom, $urandom, $urandom};
                if (r % 4 == 1) v = 128'h1 << ($urandom % 128);
                apply(v, c);
                check(c == 0 ? "R1" : c < 64 ? "R2" : c == 64 ? "R3" :
                      c < 128 ? "R4" : "R5", ref_shift(v, c));
            end
        end

        // Random counts and sparse values (R6, R8).
        for (int r = 0; r < 2000; r++) begin
            logic [7:0] c;
            c = 8'($urandom);
            v = (r % 2) ? (128'h1 << ($urandom % 128)) | (128'h1 << ($urandom % 128))
                        : {$urandom, $urandom, $urandom, $urandom};
            apply(v, c);
            check("R8", ref_shift(v, c));
        end
        summary();
    end
endmodule